// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This block sits on the write side of a memory controller. It takes a 64-bit data beat and the 8-bit check byte already computed for that beat. It forwards both to the memory one cycle later. When injection is armed, it flips chosen bits of the beat so that a test can provoke ECC errors on purpose.

The errors appear only when the location is read back. The read path crosses the block with no change. A mask with a single bit set gives a correctable single-bit error on read-back. A mask with two or more bits set gives an uncorrectable multi-bit error.

Software sets the injector up through a small register port with four word addresses. Two addresses hold the halves of a 64-bit data flip mask. One address holds an 8-bit check-byte flip mask together with read-only copies of the control bits. The last address holds the control bits: an arm bit and a mirror bit. With the mirror bit set, the check lanes carry the lowest data byte instead of the computed check byte.

Top module: `ecc_wr_injector`

## Requirements
- R1: After reset, all four register addresses read as zero and injection is off, so write beats leave the block unchanged.
- R2: A write to address 0 sets bits 63:32 of the data flip mask and a write to address 1 sets bits 31:0. Each address reads back its 32-bit half.
- R3: A write to address 2 changes only the check-byte flip mask, taken from wdata bits 7:0. The arm and mirror bits stay as they were. Address 2 reads back {22 zeros, mirror at bit 9, arm at bit 8, check mask at bits 7:0}.
- R4: A write to address 3 sets arm from wdata bit 0 and mirror from wdata bit 1, and leaves both flip masks unchanged. Address 3 reads back {30 zeros, mirror, arm}.
- R5: While arm is 0, the outgoing data and check byte equal the incoming beat exactly.
- R6: While arm is 1 and mirror is 0, outgoing data is the incoming data XOR the 64-bit data mask, and the outgoing check byte is the incoming check byte XOR the check mask. A one-bit mask changes exactly one outgoing bit.
- R7: While arm and mirror are both 1, outgoing data is masked as in R6, and the outgoing check byte equals bits 7:0 of that masked outgoing data. The check mask is not applied in this mode.
- R8: Setting mirror while arm is 0 has no effect on the outgoing beat.
- R9: Every write beat, together with its valid flag, appears at the outputs exactly one clock after it is presented. The beat is transformed using the settings that were in force in the cycle it was presented.
- R10: The read data and read check byte pass through combinationally and unchanged under every setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| wr_valid_i | input | 1 | Incoming write beat valid |
| wr_data_i | input | 64 | Incoming write data |
| wr_chk_i | input | 8 | Incoming computed check byte |
| wr_valid_o | output | 1 | Outgoing write beat valid |
| wr_data_o | output | 64 | Outgoing write data to memory |
| wr_chk_o | output | 8 | Outgoing check byte to memory |
| rd_data_i | input | 64 | Read data from memory |
| rd_chk_i | input | 8 | Read check byte from memory |
| rd_data_o | output | 64 | Read data toward the ECC checker |
| rd_chk_o | output | 8 | Read check byte toward the ECC checker |

## Verification
A corrupted mask or control bit inside the block shows up in two places. It appears on the register read port in the same cycle the address is selected. It also appears on the outgoing beat one clock after the next write is presented. A wrong arm or mirror bit changes the check byte or the data on that next beat. This is why the reference model is compared on every clock, against readback and against the write outputs alike.

The random phase mixes register writes with beats in the same cycle. That exposes any beat that uses the settings after the write instead of before it. Checking the read path on every cycle while injection is armed exposes any leakage of the masks into read data.

// File: rtl/ecci_pkg.sv
package ecci_pkg;

    parameter int unsigned DATA_W = 64;
    parameter int unsigned CHK_W  = 8;
    parameter int unsigned REG_W  = 32;
    parameter int unsigned ADDR_W = 2;

    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned LANES  = DATA_W / CHK_W;

    // bit positions of the control copies inside the check-mask word
    localparam int unsigned CHKW_ARM_POS = CHK_W;
    localparam int unsigned CHKW_MIR_POS = CHK_W + 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK_HI = 2'd0,
        RA_MASK_LO = 2'd1,
        RA_CHK     = 2'd2,
        RA_CTRL    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic arm;
        logic mirror;
    } inj_ctrl_t;

    typedef struct packed {
        logic [DATA_W-1:0] data_mask;
        logic [CHK_W-1:0]  chk_mask;
        inj_ctrl_t         ctrl;
    } inj_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
    } wr_beat_t;

    function automatic logic [REG_W-1:0] chk_word(input logic [CHK_W-1:0] m,
                                                  input inj_ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CHK_W-1:0]    = m;
        w[CHKW_ARM_POS] = c.arm;
        w[CHKW_MIR_POS] = c.mirror;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_word(input inj_ctrl_t c);
        logic [REG_W-1:0] w;
        w    = '0;
        w[0] = c.arm;
        w[1] = c.mirror;
        return w;
    endfunction

endpackage

// File: rtl/ecci_regs.sv
module ecci_regs
    import ecci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output inj_cfg_t          cfg_o
);

    reg_addr_e ra;
    assign ra = reg_addr_e'(addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '0;
        end else if (wr_en_i) begin
            case (ra)
                RA_MASK_HI: cfg_o.data_mask[DATA_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
                RA_MASK_LO: cfg_o.data_mask[HALF_W-1:0]      <= wdata_i[HALF_W-1:0];
                RA_CHK:     cfg_o.chk_mask                   <= wdata_i[CHK_W-1:0];
                RA_CTRL: begin
                    cfg_o.ctrl.arm    <= wdata_i[0];
                    cfg_o.ctrl.mirror <= wdata_i[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (ra)
            RA_MASK_HI: rdata_o[HALF_W-1:0] = cfg_o.data_mask[DATA_W-1:HALF_W];
            RA_MASK_LO: rdata_o[HALF_W-1:0] = cfg_o.data_mask[HALF_W-1:0];
            RA_CHK:     rdata_o = chk_word(cfg_o.chk_mask, cfg_o.ctrl);
            RA_CTRL:    rdata_o = ctrl_word(cfg_o.ctrl);
            default:    rdata_o = '0;
        endcase
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_o == '0));

    assert_chk_keeps_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && ra == RA_CHK) |=> $stable(cfg_o.ctrl) && $stable(cfg_o.data_mask));

    assert_ctrl_keeps_masks_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && ra == RA_CTRL) |=> $stable(cfg_o.chk_mask) && $stable(cfg_o.data_mask));

endmodule

// File: rtl/ecci_lane.sv
module ecci_lane
    import ecci_pkg::*;
(
    input  logic             arm_i,
    input  logic [CHK_W-1:0] byte_i,
    input  logic [CHK_W-1:0] flip_i,
    output logic [CHK_W-1:0] byte_o
);

    logic [CHK_W-1:0] gated;
    assign gated  = arm_i ? flip_i : '0;
    assign byte_o = byte_i ^ gated;

endmodule

// File: rtl/ecci_corrupt.sv
module ecci_corrupt
    import ecci_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  inj_cfg_t cfg_i,
    input  wr_beat_t beat_i,
    output wr_beat_t beat_o
);

    logic [DATA_W-1:0] data_x;
    logic [CHK_W-1:0]  chk_x;
    logic [CHK_W-1:0]  chk_sel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ecci_lane u_lane (
            .arm_i  (cfg_i.ctrl.arm),
            .byte_i (beat_i.data[g*CHK_W +: CHK_W]),
            .flip_i (cfg_i.data_mask[g*CHK_W +: CHK_W]),
            .byte_o (data_x[g*CHK_W +: CHK_W])
        );
    end

    ecci_lane u_chk_lane (
        .arm_i  (cfg_i.ctrl.arm),
        .byte_i (beat_i.chk),
        .flip_i (cfg_i.chk_mask),
        .byte_o (chk_x)
    );

    always_comb begin
        if (cfg_i.ctrl.arm && cfg_i.ctrl.mirror) begin
            chk_sel = data_x[CHK_W-1:0];
        end else begin
            chk_sel = chk_x;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else begin
            beat_o.valid <= beat_i.valid;
            beat_o.data  <= data_x;
            beat_o.chk   <= chk_sel;
        end
    end

    assert_pass_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        (beat_i.valid && !cfg_i.ctrl.arm) |=>
            (beat_o.data == $past(beat_i.data)) && (beat_o.chk == $past(beat_i.chk)));

    assert_data_flip_R6: assert property (@(posedge clk) disable iff (rst)
        (beat_i.valid && cfg_i.ctrl.arm) |=>
            ((beat_o.data ^ $past(beat_i.data)) == $past(cfg_i.data_mask)));

    assert_chk_flip_R6: assert property (@(posedge clk) disable iff (rst)
        (beat_i.valid && cfg_i.ctrl.arm && !cfg_i.ctrl.mirror) |=>
            ((beat_o.chk ^ $past(beat_i.chk)) == $past(cfg_i.chk_mask)));

    assert_mirror_byte_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_i.valid && cfg_i.ctrl.arm && cfg_i.ctrl.mirror) |=>
            (beat_o.chk == beat_o.data[CHK_W-1:0]));

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        beat_i.valid |=> beat_o.valid);

endmodule

// File: rtl/ecc_wr_injector.sv
module ecc_wr_injector
    import ecci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [CHK_W-1:0]  wr_chk_i,
    output logic              wr_valid_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [CHK_W-1:0]  wr_chk_o,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [CHK_W-1:0]  rd_chk_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CHK_W-1:0]  rd_chk_o
);

    inj_cfg_t cfg;
    wr_beat_t beat_in;
    wr_beat_t beat_out;

    ecci_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (reg_wr_en),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .cfg_o   (cfg)
    );

    assign beat_in.valid = wr_valid_i;
    assign beat_in.data  = wr_data_i;
    assign beat_in.chk   = wr_chk_i;

    ecci_corrupt u_corrupt (
        .clk    (clk),
        .rst    (rst),
        .cfg_i  (cfg),
        .beat_i (beat_in),
        .beat_o (beat_out)
    );

    assign wr_valid_o = beat_out.valid;
    assign wr_data_o  = beat_out.data;
    assign wr_chk_o   = beat_out.chk;

    // read side crosses untouched
    assign rd_data_o = rd_data_i;
    assign rd_chk_o  = rd_chk_i;

endmodule

// File: tb/test_ecc_wr_injector.sv
module test_ecc_wr_injector;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wr_valid_i = 1'b0;
    logic [63:0] wr_data_i = '0;
    logic [7:0]  wr_chk_i = '0;
    logic        wr_valid_o;
    logic [63:0] wr_data_o;
    logic [7:0]  wr_chk_o;
    logic [63:0] rd_data_i = '0;
    logic [7:0]  rd_chk_i = '0;
    logic [63:0] rd_data_o;
    logic [7:0]  rd_chk_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ecc_wr_injector i_ecc_wr_injector (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_chk_i(wr_chk_i),
        .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .wr_chk_o(wr_chk_o),
        .rd_data_i(rd_data_i), .rd_chk_i(rd_chk_i),
        .rd_data_o(rd_data_o), .rd_chk_o(rd_chk_o)
    );

    // behavioural reference model
    logic [31:0] m_hi, m_lo;
    logic [7:0]  m_cm;
    logic        m_arm, m_mir;
    logic        exp_v;
    logic [63:0] exp_d;
    logic [7:0]  exp_c;
    string       exp_tag = "R1";

    always @(posedge clk) begin
        if (rst) begin
            m_hi = '0; m_lo = '0; m_cm = '0; m_arm = 0; m_mir = 0;
            exp_v = 0; exp_d = '0; exp_c = '0; exp_tag = "R1";
        end else begin
            exp_v = wr_valid_i;
            if (m_arm) begin
                exp_d = wr_data_i ^ {m_hi, m_lo};
                exp_c = m_mir ? exp_d[7:0] : (wr_chk_i ^ m_cm);
                exp_tag = m_mir ? "R7" : "R6";
            end else begin
                exp_d = wr_data_i;
                exp_c = wr_chk_i;
                exp_tag = m_mir ? "R8" : "R5";
            end
            if (reg_wr_en) begin
                case (reg_addr)
                    2'd0: m_hi = reg_wdata;
                    2'd1: m_lo = reg_wdata;
                    2'd2: m_cm = reg_wdata[7:0];
                    default: begin m_arm = reg_wdata[0]; m_mir = reg_wdata[1]; end
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_hi;
            2'd1:    return m_lo;
            2'd2:    return {22'd0, m_mir, m_arm, m_cm};
            default: return {30'd0, m_mir, m_arm};
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R9 valid", {63'd0, wr_valid_o}, {63'd0, exp_v});
            check({exp_tag, " data"}, wr_data_o, exp_d);
            check({exp_tag, " chk"}, {56'd0, wr_chk_o}, {56'd0, exp_c});
            check("R10 rd data", rd_data_o, rd_data_i);
            check("R10 rd chk", {56'd0, rd_chk_o}, {56'd0, rd_chk_i});
            case (reg_addr)
                2'd0, 2'd1: check("R2 readback", {32'd0, reg_rdata}, {32'd0, exp_rd(reg_addr)});
                2'd2:       check("R3 readback", {32'd0, reg_rdata}, {32'd0, exp_rd(reg_addr)});
                default:    check("R4 readback", {32'd0, reg_rdata}, {32'd0, exp_rd(reg_addr)});
            endcase
        end
    end

    task automatic step(input logic we, input logic [1:0] a, input logic [31:0] wd,
                        input logic v, input logic [63:0] d, input logic [7:0] c);
        @(posedge clk);
        #2;
        reg_wr_en  = we;
        reg_addr   = a;
        reg_wdata  = wd;
        wr_valid_i = v;
        wr_data_i  = d;
        wr_chk_i   = c;
        rd_data_i  = {$urandom, $urandom};
        rd_chk_i   = 8'($urandom);
    endtask

    task automatic beats(input int n);
        for (int k = 0; k < n; k++)
            step(0, 2'(k), 32'd0, 1'b1, {$urandom, $urandom}, 8'($urandom));
    endtask

    task automatic regw(input logic [1:0] a, input logic [31:0] wd);
        step(1, a, wd, 1'b0, 64'd0, 8'd0);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1: every register reads zero after reset
        for (int a = 0; a < 4; a++) begin
            step(0, 2'(a), 32'd0, 1'b0, 64'd0, 8'd0);
            @(negedge clk);
            check("R1 reset readback", {32'd0, reg_rdata}, 64'd0);
        end
        check("R1 reset out valid", {63'd0, wr_valid_o}, 64'd0);
        beats(8);                              // R5 pass-through
        regw(2'd0, 32'h0000_0001);             // R2 single-bit mask high
        regw(2'd3, 32'd1);                     // R4 arm
        beats(6);                              // R6 one-bit flip
        regw(2'd0, 32'h0000_0005);             // multi-bit
        regw(2'd1, 32'h8000_0010);
        beats(6);
        regw(2'd2, 32'hFFFF_FFA5);             // R3 only bits 7:0 land
        step(0, 2'd3, 32'd0, 1'b0, 64'd0, 8'd0);
        @(negedge clk);
        check("R3 arm kept", {32'd0, reg_rdata}, 64'd1);
        beats(6);
        regw(2'd3, 32'd3);                     // R7 mirror
        beats(6);
        regw(2'd3, 32'd2);                     // R8 mirror without arm
        beats(6);
        regw(2'd3, 32'd3);
        regw(2'd2, 32'h0000_003C);
        step(0, 2'd2, 32'd0, 1'b0, 64'd0, 8'd0);
        @(negedge clk);
        check("R3 word", {32'd0, reg_rdata}, 64'h33C);
        // R9: config changes in the same cycle as beats
        for (int k = 0; k < 400; k++)
            step(($urandom % 3) == 0, 2'($urandom), $urandom,
                 1'($urandom), {$urandom, $urandom}, 8'($urandom));
        regw(2'd3, 32'd0);
        beats(4);
        step(0, 2'd0, 32'd0, 1'b0, 64'd0, 8'd0);
        @(negedge clk);
        #1 done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R9 actual hung expected finish");
            summary();
            $finish;
        end
    end

endmodule